// File: doc/BRIEF.md
# Power-Management Register File with Interrupt Combining

This block is the register side of a power-management companion device. A serial bus slave elsewhere turns each bus frame into one request on a simple register port: a valid strobe, a read/write flag, a 5-bit register index and 16-bit write data. The block answers every request one cycle later with registered read data and an error flag. Behind the port sit an identification word, an interrupt status and mask pair, an ADC result window with preset per-channel samples, a block of plain storage registers that includes the common control word and a watchdog word.

Three event inputs feed the interrupt status: a power key, a headset detector and a hook detector. The headset and hook detectors also move the ADC sample on their own channel. All unmasked pending sources are ORed into a single registered interrupt line. A zero written to the watchdog word while the control word arms it raises a sticky shutdown request.

Top module: `pm_regfile`

## Requirements
- R1: A read of index 0x00 returns 0x0215, with bit 7 also set while `variant_sel` is high. Writes to index 0x00 have no effect.
- R2: Index 0x02 is a 9-bit mask that reads back zero-extended. `irq` is high one cycle after any bit of (status AND NOT mask) is 1, so a mask bit of 1 silences that source.
- R3: Index 0x01 reads the 9-bit interrupt status, zero-extended. Writing it clears each status bit whose write-data bit is 1 and leaves the bits written as 0.
- R4: A one-cycle pulse on `pwr_key_evt` sets status bit 0. The other sources are bit 6 hook, bit 7 headset and bit 8 ADC sample. A source that sets a bit in the same cycle as a clear wins.
- R5: A `headset_evt` pulse sets status bit 7 and a `hook_evt` pulse sets status bit 6. Each does so only while bits 8 and 10 of the control word at index 0x0d are both 1.
- R6: Each headset or hook pulse sets the sample of its channel (4 for headset, 5 for hook) to 50 when its level input `headset_on`/`hook_on` is 1, and to 123 when it is 0. The event gating of R5 does not affect this. Both samples are 123 after reset.
- R7: A write to index 0x08 selects the channel from write-data bits [13:10] and sets status bit 8. A read of index 0x08 returns (channel << 10) OR the channel's 10-bit sample. Every channel other than 4 and 5 holds the fixed sample channel*65. The channel is 0 after reset.
- R8: Writing 0x0000 to index 0x17 while bit 1 of the control word at 0x0d is 1 raises `shutdown_req` on the next cycle, and it stays high until reset. A nonzero value, or an unarmed control word, leaves it low.
- R9: Indices 0x07, 0x12, 0x13, 0x14 and 0x15 are undefined. Any access to one of them pulses `rsp_err` high for exactly one cycle, a read returns 0 and a write changes nothing.
- R10: Every other index is a 16-bit storage register that is 0 after reset and reads back the last value written. Read data appears on `rsp_rdata` in the cycle after the request and holds until the next read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| variant_sel | input | 1 | Selects the alternate identification value |
| req_valid | input | 1 | Register request strobe, one cycle per access |
| req_write | input | 1 | 1 = write, 0 = read |
| req_index | input | 5 | Register index |
| req_wdata | input | 16 | Write data |
| rsp_rdata | output | 16 | Registered read data |
| rsp_err | output | 1 | One-cycle pulse for an undefined index |
| pwr_key_evt | input | 1 | Power-key event pulse |
| headset_evt | input | 1 | Headset event pulse |
| headset_on | input | 1 | Headset level, sampled with its pulse |
| hook_evt | input | 1 | Hook event pulse |
| hook_on | input | 1 | Hook level, sampled with its pulse |
| irq | output | 1 | Combined unmasked interrupt |
| shutdown_req | output | 1 | Sticky shutdown request |

## Verification
Read data, the error flag, status changes and the shutdown request all come from the clock edge that takes the request or the event. They can therefore be observed at the falling edge that follows it. The interrupt line is registered once more from the status and mask, so it is due one clock later. Every scenario task drives its inputs on a falling edge. It samples the port-visible results at the falling edge where they are due, and for `irq` it waits one extra falling edge.

// File: rtl/pmreg_pkg.sv
package pmreg_pkg;

   typedef enum logic [2:0] {
      RK_NONE,
      RK_ID,
      RK_STAT,
      RK_MASK,
      RK_ADC,
      RK_WDOG,
      RK_PLAIN
   } reg_kind_e;

   localparam int unsigned IDX_ID    = 0;
   localparam int unsigned IDX_STAT  = 1;
   localparam int unsigned IDX_MASK  = 2;
   localparam int unsigned IDX_ADC   = 8;
   localparam int unsigned IDX_CCR1  = 13;
   localparam int unsigned IDX_WDOG  = 23;

   localparam int unsigned SRC_PWR   = 0;
   localparam int unsigned SRC_HOOK  = 6;
   localparam int unsigned SRC_HEAD  = 7;
   localparam int unsigned SRC_ADC   = 8;

   function automatic reg_kind_e kind_of(input int unsigned idx);
      reg_kind_e k;
      case (idx)
         IDX_ID:                k = RK_ID;
         IDX_STAT:              k = RK_STAT;
         IDX_MASK:              k = RK_MASK;
         IDX_ADC:               k = RK_ADC;
         IDX_WDOG:              k = RK_WDOG;
         7, 18, 19, 20, 21:     k = RK_NONE;
         default:               k = RK_PLAIN;
      endcase
      return k;
   endfunction

   // fixed sample for channels without a live detector
   function automatic logic [15:0] adc_preset(input int unsigned ch);
      return 16'(ch * 65);
   endfunction

endpackage

// File: rtl/pm_idx_decode.sv
module pm_idx_decode
   import pmreg_pkg::*;
#(
   parameter int unsigned IDX_W = 5
) (
   input  logic [IDX_W-1:0] index,
   output reg_kind_e        kind
);
   always_comb kind = kind_of(int'(index));
endmodule

// File: rtl/pm_irq_ctrl.sv
module pm_irq_ctrl #(
   parameter int unsigned NSRC = 9
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic [NSRC-1:0] set_vec,
   input  logic            clr_we,
   input  logic [NSRC-1:0] clr_vec,
   input  logic            mask_we,
   input  logic [NSRC-1:0] mask_wdata,
   output logic [NSRC-1:0] status,
   output logic [NSRC-1:0] mask,
   output logic            irq
);
   logic [NSRC-1:0] clr_eff;
   logic [NSRC-1:0] status_d;

   always_comb begin
      clr_eff  = clr_we ? clr_vec : '0;
      status_d = (status & ~clr_eff) | set_vec;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         status <= '0;
         mask   <= '0;
         irq    <= 1'b0;
      end else begin
         status <= status_d;
         if (mask_we) mask <= mask_wdata;
         irq    <= |(status & ~mask);
      end
   end
endmodule

// File: rtl/pm_adc_bank.sv
module pm_adc_bank
   import pmreg_pkg::*;
#(
   parameter int unsigned DATA_W     = 16,
   parameter int unsigned CH_W       = 4,
   parameter int unsigned RES_W      = 10,
   parameter int unsigned HEAD_CH    = 4,
   parameter int unsigned HOOK_CH    = 5,
   parameter int unsigned ACTIVE_VAL = 50,
   parameter int unsigned IDLE_VAL   = 123
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              sel_we,
   input  logic [CH_W-1:0]   sel_ch,
   input  logic              head_evt,
   input  logic              head_on,
   input  logic              hook_evt,
   input  logic              hook_on,
   output logic [DATA_W-1:0] rd_value
);
   localparam int unsigned NCH = 1 << CH_W;

   if (CH_W + RES_W > DATA_W) begin : g_bad_width
      $error("channel and sample fields exceed the data width");
   end
   if (HEAD_CH == HOOK_CH || HEAD_CH >= NCH || HOOK_CH >= NCH) begin : g_bad_ch
      $error("detector channels must differ and fit the channel field");
   end

   logic [CH_W-1:0]  chan_q;
   logic [RES_W-1:0] head_res_q;
   logic [RES_W-1:0] hook_res_q;
   logic [RES_W-1:0] sample;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         chan_q     <= '0;
         head_res_q <= RES_W'(IDLE_VAL);
         hook_res_q <= RES_W'(IDLE_VAL);
      end else begin
         if (sel_we)   chan_q     <= sel_ch;
         if (head_evt) head_res_q <= head_on ? RES_W'(ACTIVE_VAL) : RES_W'(IDLE_VAL);
         if (hook_evt) hook_res_q <= hook_on ? RES_W'(ACTIVE_VAL) : RES_W'(IDLE_VAL);
      end
   end

   always_comb begin
      if (int'(chan_q) == HEAD_CH)      sample = head_res_q;
      else if (int'(chan_q) == HOOK_CH) sample = hook_res_q;
      else                              sample = RES_W'(adc_preset(int'(chan_q)));
      rd_value = DATA_W'({chan_q, sample});
   end
endmodule

// File: rtl/pm_regfile.sv
module pm_regfile
   import pmreg_pkg::*;
#(
   parameter int unsigned   DATA_W   = 16,
   parameter int unsigned   IDX_W    = 5,
   parameter int unsigned   NSRC     = 9,
   parameter int unsigned   CH_W     = 4,
   parameter int unsigned   RES_W    = 10,
   parameter int unsigned   HEAD_CH  = 4,
   parameter int unsigned   HOOK_CH  = 5,
   parameter logic [15:0]   ID_VALUE = 16'h0215,
   parameter int unsigned   VAR_BIT  = 7
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              variant_sel,
   input  logic              req_valid,
   input  logic              req_write,
   input  logic [IDX_W-1:0]  req_index,
   input  logic [DATA_W-1:0] req_wdata,
   output logic [DATA_W-1:0] rsp_rdata,
   output logic              rsp_err,
   input  logic              pwr_key_evt,
   input  logic              headset_evt,
   input  logic              headset_on,
   input  logic              hook_evt,
   input  logic              hook_on,
   output logic              irq,
   output logic              shutdown_req
);
   localparam int unsigned NREG = 1 << IDX_W;
   localparam int unsigned ADC_LSB = DATA_W - 6;

   if (DATA_W != 16) begin : g_bad_data
      $error("register slots are 16 bits wide");
   end
   if (NSRC <= SRC_ADC || NSRC > DATA_W) begin : g_bad_nsrc
      $error("interrupt source count must cover the ADC source");
   end
   if (NREG <= IDX_WDOG) begin : g_bad_idx
      $error("index width too small for the register map");
   end

   reg_kind_e        kind;
   logic             wr_en;
   logic             rd_en;
   logic [NSRC-1:0]  irq_status;
   logic [NSRC-1:0]  irq_mask;
   logic [NSRC-1:0]  set_vec;
   logic [DATA_W-1:0] adc_rd;
   logic [DATA_W-1:0] store_w [NREG];
   logic [DATA_W-1:0] ccr1;
   logic             evt_gate;
   logic [DATA_W-1:0] rd_mux;
   logic [DATA_W-1:0] id_word;
   logic             sd_q;

   pm_idx_decode #(.IDX_W(IDX_W)) u_dec (
      .index (req_index),
      .kind  (kind)
   );

   assign wr_en = req_valid &  req_write;
   assign rd_en = req_valid & ~req_write;

   for (genvar i = 0; i < NREG; i++) begin : g_slot
      if (kind_of(i) == RK_PLAIN || kind_of(i) == RK_WDOG) begin : g_store
         logic [DATA_W-1:0] cell_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)                                  cell_q <= '0;
            else if (wr_en && int'(req_index) == i)      cell_q <= req_wdata;
         end
         assign store_w[i] = cell_q;
      end else begin : g_tie
         assign store_w[i] = '0;
      end
   end

   assign ccr1     = store_w[IDX_CCR1];
   assign evt_gate = ccr1[8] & ccr1[10];

   always_comb begin
      set_vec           = '0;
      set_vec[SRC_PWR]  = pwr_key_evt;
      set_vec[SRC_HOOK] = hook_evt & evt_gate;
      set_vec[SRC_HEAD] = headset_evt & evt_gate;
      set_vec[SRC_ADC]  = wr_en && kind == RK_ADC;
   end

   pm_irq_ctrl #(.NSRC(NSRC)) u_irq (
      .clk        (clk),
      .rst_n      (rst_n),
      .set_vec    (set_vec),
      .clr_we     (wr_en && kind == RK_STAT),
      .clr_vec    (req_wdata[NSRC-1:0]),
      .mask_we    (wr_en && kind == RK_MASK),
      .mask_wdata (req_wdata[NSRC-1:0]),
      .status     (irq_status),
      .mask       (irq_mask),
      .irq        (irq)
   );

   pm_adc_bank #(
      .DATA_W  (DATA_W),
      .CH_W    (CH_W),
      .RES_W   (RES_W),
      .HEAD_CH (HEAD_CH),
      .HOOK_CH (HOOK_CH)
   ) u_adc (
      .clk      (clk),
      .rst_n    (rst_n),
      .sel_we   (wr_en && kind == RK_ADC),
      .sel_ch   (req_wdata[ADC_LSB+CH_W-1:ADC_LSB]),
      .head_evt (headset_evt),
      .head_on  (headset_on),
      .hook_evt (hook_evt),
      .hook_on  (hook_on),
      .rd_value (adc_rd)
   );

   always_comb begin
      id_word          = ID_VALUE;
      id_word[VAR_BIT] = id_word[VAR_BIT] | variant_sel;
      case (kind)
         RK_ID:   rd_mux = id_word;
         RK_STAT: rd_mux = DATA_W'(irq_status);
         RK_MASK: rd_mux = DATA_W'(irq_mask);
         RK_ADC:  rd_mux = adc_rd;
         RK_NONE: rd_mux = '0;
         default: rd_mux = store_w[req_index];
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rsp_rdata <= '0;
         rsp_err   <= 1'b0;
         sd_q      <= 1'b0;
      end else begin
         if (rd_en) rsp_rdata <= rd_mux;
         rsp_err <= req_valid && kind == RK_NONE;
         if (wr_en && kind == RK_WDOG && req_wdata == '0 && ccr1[1]) sd_q <= 1'b1;
      end
   end

   assign shutdown_req = sd_q;
endmodule

// File: rtl/pm_regfile_chk.sv
module pm_regfile_chk #(
   parameter int unsigned DATA_W   = 16,
   parameter int unsigned IDX_W    = 5,
   parameter int unsigned NSRC     = 9,
   parameter logic [15:0] ID_VALUE = 16'h0215
) (
   input logic              clk,
   input logic              rst_n,
   input logic              variant_sel,
   input logic              req_valid,
   input logic              req_write,
   input logic [IDX_W-1:0]  req_index,
   input logic [DATA_W-1:0] rsp_rdata,
   input logic              rsp_err,
   input logic              pwr_key_evt,
   input logic              irq,
   input logic              shutdown_req,
   input logic [NSRC-1:0]   status,
   input logic [NSRC-1:0]   mask
);
   assert_id_read_R1: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && !req_write && req_index == '0) |=>
      (rsp_rdata == (DATA_W'(ID_VALUE) | (DATA_W'($past(variant_sel)) << 7))));

   assert_masked_quiet_R2: assert property (@(posedge clk) disable iff (!rst_n)
      ((status & ~mask) == '0) |=> !irq);

   assert_pwr_sets_R4: assert property (@(posedge clk) disable iff (!rst_n)
      pwr_key_evt |=> status[0]);

   assert_adc_sets_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && req_write && req_index == IDX_W'(8)) |=> status[8]);

   assert_shutdown_sticky_R8: assert property (@(posedge clk) disable iff (!rst_n)
      shutdown_req |=> shutdown_req);

   assert_err_after_req_R9: assert property (@(posedge clk) disable iff (!rst_n)
      rsp_err |-> $past(req_valid));
endmodule

bind pm_regfile pm_regfile_chk #(
   .DATA_W   (DATA_W),
   .IDX_W    (IDX_W),
   .NSRC     (NSRC),
   .ID_VALUE (ID_VALUE)
) u_chk (
   .clk          (clk),
   .rst_n        (rst_n),
   .variant_sel  (variant_sel),
   .req_valid    (req_valid),
   .req_write    (req_write),
   .req_index    (req_index),
   .rsp_rdata    (rsp_rdata),
   .rsp_err      (rsp_err),
   .pwr_key_evt  (pwr_key_evt),
   .irq          (irq),
   .shutdown_req (shutdown_req),
   .status       (irq_status),
   .mask         (irq_mask)
);

// File: tb/pm_regfile_test.sv
module pm_regfile_test;
   localparam int CLK_PERIOD = 10;

   logic        clk = 0;
   logic        rst_n = 0;
   logic        variant_sel = 0;
   logic        req_valid = 0;
   logic        req_write = 0;
   logic [4:0]  req_index = '0;
   logic [15:0] req_wdata = '0;
   logic [15:0] rsp_rdata;
   logic        rsp_err;
   logic        pwr_key_evt = 0;
   logic        headset_evt = 0;
   logic        headset_on = 0;
   logic        hook_evt = 0;
   logic        hook_on = 0;
   logic        irq;
   logic        shutdown_req;

   int n_run = 0;
   int n_fail = 0;
   bit done = 0;

   always #(CLK_PERIOD/2) clk = ~clk;

   pm_regfile uut (.*);

   task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
      n_run++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: actual 0x%04h expected 0x%04h", req, act, exp);
      end
   endtask

   task automatic bus_wr(input logic [4:0] idx, input logic [15:0] d);
      @(negedge clk);
      req_valid = 1; req_write = 1; req_index = idx; req_wdata = d;
      @(negedge clk);
      req_valid = 0; req_write = 0;
   endtask

   task automatic bus_rd(input logic [4:0] idx, output logic [15:0] d, output logic e);
      @(negedge clk);
      req_valid = 1; req_write = 0; req_index = idx;
      @(negedge clk);
      req_valid = 0;
      d = rsp_rdata; e = rsp_err;
   endtask

   task automatic expect_rd(input string req, input logic [4:0] idx, input logic [15:0] exp);
      logic [15:0] d; logic e;
      bus_rd(idx, d, e);
      check(req, d, exp);
   endtask

   task automatic t_reset();
      check("R10 reset rdata", rsp_rdata, 16'h0);
      check("R2 reset irq", 16'(irq), 16'h0);
      check("R8 reset shutdown", 16'(shutdown_req), 16'h0);
      check("R9 reset err", 16'(rsp_err), 16'h0);
      expect_rd("R3 reset status", 5'h01, 16'h0000);
   endtask

   task automatic t_id();
      expect_rd("R1 id plain", 5'h00, 16'h0215);
      variant_sel = 1;
      expect_rd("R1 id variant", 5'h00, 16'h0295);
      variant_sel = 0;
      bus_wr(5'h00, 16'h0000);
      expect_rd("R1 id write ignored", 5'h00, 16'h0215);
   endtask

   task automatic t_irq();
      @(negedge clk); pwr_key_evt = 1;
      @(negedge clk); pwr_key_evt = 0;
      @(negedge clk);
      check("R2 irq raised", 16'(irq), 16'h1);
      expect_rd("R4 power key bit", 5'h01, 16'h0001);
      bus_wr(5'h02, 16'h0001);
      @(negedge clk);
      check("R2 irq masked", 16'(irq), 16'h0);
      expect_rd("R2 mask readback", 5'h02, 16'h0001);
      bus_wr(5'h02, 16'h0000);
      bus_wr(5'h01, 16'h0000);
      expect_rd("R3 zero write keeps", 5'h01, 16'h0001);
      bus_wr(5'h01, 16'h0001);
      expect_rd("R3 w1c clears", 5'h01, 16'h0000);
      @(negedge clk);
      check("R2 irq drops", 16'(irq), 16'h0);
   endtask

   task automatic t_detect();
      bus_wr(5'h0d, 16'h0000);
      @(negedge clk); headset_on = 1; headset_evt = 1;
      @(negedge clk); headset_evt = 0;
      expect_rd("R5 headset gated off", 5'h01, 16'h0000);
      bus_wr(5'h08, 16'h1000);
      expect_rd("R6 headset active 50", 5'h08, 16'h1032);
      bus_wr(5'h01, 16'h01FF);
      bus_wr(5'h0d, 16'h0100);
      @(negedge clk); hook_on = 0; hook_evt = 1;
      @(negedge clk); hook_evt = 0;
      expect_rd("R5 half gate no set", 5'h01, 16'h0000);
      bus_wr(5'h0d, 16'h0500);
      @(negedge clk); headset_on = 1; headset_evt = 1;
      @(negedge clk); headset_evt = 0;
      @(negedge clk); hook_on = 0; hook_evt = 1;
      @(negedge clk); hook_evt = 0;
      expect_rd("R5 both set", 5'h01, 16'h00C0);
      bus_wr(5'h08, 16'h1400);
      expect_rd("R6 hook idle 123", 5'h08, 16'h147B);
      @(negedge clk); headset_on = 0; headset_evt = 1;
      @(negedge clk); headset_evt = 0;
      bus_wr(5'h08, 16'h1000);
      expect_rd("R6 headset idle 123", 5'h08, 16'h107B);
      bus_wr(5'h01, 16'h01FF);
      bus_wr(5'h0d, 16'h0000);
   endtask

   task automatic t_adc();
      bus_wr(5'h08, 16'h0C00);
      expect_rd("R7 adc sets bit8", 5'h01, 16'h0100);
      expect_rd("R7 ch3 preset", 5'h08, 16'h0CC3);
      bus_wr(5'h08, 16'hFFFF);
      expect_rd("R7 ch15 upper bits dropped", 5'h08, 16'h3FCF);
      bus_wr(5'h01, 16'h0100);
   endtask

   task automatic t_undef();
      logic [15:0] d; logic e;
      bus_rd(5'h07, d, e);
      check("R9 undef read data", d, 16'h0000);
      check("R9 undef err", 16'(e), 16'h1);
      @(negedge clk);
      check("R9 err one cycle", 16'(rsp_err), 16'h0);
      bus_wr(5'h12, 16'hABCD);
      check("R9 undef write err", 16'(rsp_err), 16'h1);
      expect_rd("R9 undef write no effect", 5'h12, 16'h0000);
      expect_rd("R9 status untouched", 5'h01, 16'h0000);
   endtask

   task automatic t_store();
      bus_wr(5'h1f, 16'hBEEF);
      bus_wr(5'h03, 16'h1234);
      expect_rd("R10 slot 1f", 5'h1f, 16'hBEEF);
      expect_rd("R10 slot 03", 5'h03, 16'h1234);
      expect_rd("R10 untouched slot", 5'h10, 16'h0000);
   endtask

   task automatic t_wdog();
      bus_wr(5'h0d, 16'h0000);
      bus_wr(5'h17, 16'h0000);
      check("R8 unarmed no shutdown", 16'(shutdown_req), 16'h0);
      bus_wr(5'h0d, 16'h0002);
      bus_wr(5'h17, 16'h0005);
      check("R8 nonzero no shutdown", 16'(shutdown_req), 16'h0);
      expect_rd("R10 watchdog readback", 5'h17, 16'h0005);
      bus_wr(5'h17, 16'h0000);
      check("R8 shutdown raised", 16'(shutdown_req), 16'h1);
      bus_wr(5'h17, 16'h0007);
      check("R8 shutdown sticky", 16'(shutdown_req), 16'h1);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1;
      @(negedge clk);
      t_reset();
      t_id();
      t_irq();
      t_detect();
      t_adc();
      t_undef();
      t_store();
      t_wdog();
      if (!done) begin
         done = 1;
         $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
         $finish;
      end
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         done = 1;
         n_run++; n_fail++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
         $finish;
      end
   end
endmodule